// File: doc/BRIEF.md
# LUT Ramp Pattern Sequencer

This block plays brightness patterns out of a shared lookup table of 9-bit entries. Each channel owns a walker that steps through a window of the table bounded by a low and a high index. It holds every entry for a programmed number of millisecond ticks and presents the selected entry as the duty value for that channel's PWM. A five-bit walk configuration per channel picks the direction, one-shot or repeat, ping-pong reversal, and optional pauses at the high and low ends. Each pause lasts a multiple of the step time.

Software fills the table through a single write port and programs each channel's window, step length, pause multipliers and configuration. It then writes a channel bitmask to a shared start strobe. Every channel whose bit is set launches in the same cycle. The millisecond tick is a one-cycle input pulse, and the PWM that consumes the duty value is outside this block.

Top module: `lut_ramp_seq`

## Requirements
- R1: After reset every channel is idle, with duty 0, busy 0 and done 0, and every table entry reads 0.
- R2: A write with `lut_we` stores `lut_wdata` at `lut_addr`. A running or finished channel drives on its duty output the table entry at its current index, and a write to that entry shows on the output in the next cycle.
- R3: Channel c starts only when a cycle has both `start_we` high and `start_mask[c]` high. A channel whose mask bit is 0 is unaffected. A start is ignored while the channel's `ramp_en` bit is low.
- R4: Walk configuration bit 4 selects the direction: 1 walks from low to high starting at the low index, and 0 walks from high to low starting at the high index. Each entry is held for `step_len` ticks of `ms_tick` (0 counts as 1), and nothing advances in a cycle without a tick.
- R5: With bit 3 (repeat) set and bit 2 clear, the walker returns to its start index after the step of the last entry and the walk continues.
- R6: With bit 3 clear, after one pass the channel holds the last entry on duty, drives done 1 and busy 0, and stays so until restarted or disabled. In ping-pong mode one pass runs out and back again.
- R7: With bit 2 (ping-pong) set, reaching an end reverses the direction, and the next entry is the neighbour of the end entry, so the end entry is not repeated.
- R8: With bit 1 set and a nonzero high multiplier, reaching the high end holds the high entry for a further multiplier × step ticks.
- R9: With bit 0 set and a nonzero low multiplier, the start entry is held for a low pause before walking. In ping-pong mode the same pause is also applied on reaching the low end.
- R10: When the low index equals the high index, the window is the whole table, from 0 to the last entry.
- R11: When a channel's `ramp_en` bit is low, the channel is idle in the next cycle, with duty 0 and busy 0 and done 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle millisecond tick pulse |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | IDX_W | Table write index |
| lut_wdata | input | DUTY_W | Table write data |
| start_we | input | 1 | Shared start strobe |
| start_mask | input | NCH | Channels to launch with the strobe |
| ramp_en | input | NCH | Per-channel ramp enable |
| walk_cfg | input | NCH*5 | Per-channel walk configuration, 5 bits each |
| lo_idx | input | NCH*IDX_W | Per-channel low index |
| hi_idx | input | NCH*IDX_W | Per-channel high index |
| step_len | input | NCH*STEP_W | Per-channel ticks per step |
| hi_mult | input | NCH*PAUSE_W | Per-channel high pause, in steps |
| lo_mult | input | NCH*PAUSE_W | Per-channel low pause, in steps |
| duty | output | NCH*DUTY_W | Per-channel duty value |
| busy | output | NCH | Channel walking or pausing |
| done | output | NCH | Channel finished a one-shot pass |

## Verification
The properties assume that the low index never exceeds the high index, and that a channel's window, step, pause and configuration inputs stay fixed while it runs, changing only around a restart. They also assume no table write lands during the cycles in which duty stability is claimed. The stimulus follows these rules: it reprograms a channel only in the cycle that restarts it or while it is idle. Its one table rewrite during a run is a deliberate check on the duty path, made while the tick is held low.

// File: rtl/lut_ramp_seq.sv
module lut_ramp_seq #(
  parameter int NCH     = 2,
  parameter int IDX_W   = 4,
  parameter int DUTY_W  = 9,
  parameter int STEP_W  = 9,
  parameter int PAUSE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ms_tick,
  input  logic                    lut_we,
  input  logic [IDX_W-1:0]        lut_addr,
  input  logic [DUTY_W-1:0]       lut_wdata,
  input  logic                    start_we,
  input  logic [NCH-1:0]          start_mask,
  input  logic [NCH-1:0]          ramp_en,
  input  logic [NCH*5-1:0]        walk_cfg,
  input  logic [NCH*IDX_W-1:0]    lo_idx,
  input  logic [NCH*IDX_W-1:0]    hi_idx,
  input  logic [NCH*STEP_W-1:0]   step_len,
  input  logic [NCH*PAUSE_W-1:0]  hi_mult,
  input  logic [NCH*PAUSE_W-1:0]  lo_mult,
  output logic [NCH*DUTY_W-1:0]   duty,
  output logic [NCH-1:0]          busy,
  output logic [NCH-1:0]          done
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DUTY_W-1:0] lut [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) lut[k] <= '0;
    end else if (lut_we) begin
      lut[lut_addr] <= lut_wdata;
    end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    typedef enum logic [1:0] {IDLE, RUN, PAUSE, HALT} st_t;
    st_t st, st_n;
    logic [IDX_W-1:0]   idx, idx_n, lo_e, hi_e, term, aft_idx;
    logic               dir, dir_n, idir, idir_n, pstart, pstart_n;
    logic [STEP_W-1:0]  tcnt, tcnt_n;
    logic [PAUSE_W-1:0] pcnt, pcnt_n;
    logic               step_end, lop_on, hip_on, aft_halt, aft_dir;

    wire [4:0]         cf   = walk_cfg[c*5 +: 5];
    wire [IDX_W-1:0]   lo   = lo_idx[c*IDX_W +: IDX_W];
    wire [IDX_W-1:0]   hi   = hi_idx[c*IDX_W +: IDX_W];
    wire [STEP_W-1:0]  stp  = step_len[c*STEP_W +: STEP_W];
    wire [PAUSE_W-1:0] lo_m = lo_mult[c*PAUSE_W +: PAUSE_W];
    wire [PAUSE_W-1:0] hi_m = hi_mult[c*PAUSE_W +: PAUSE_W];

    assign lo_e     = (lo == hi) ? '0 : lo;
    assign hi_e     = (lo == hi) ? '1 : hi;
    assign term     = dir ? hi_e : lo_e;
    assign step_end = ms_tick && (({1'b0, tcnt} + 1'b1) >= {1'b0, stp});
    assign lop_on   = cf[0] && (lo_m != '0);
    assign hip_on   = cf[1] && (hi_m != '0);
    assign aft_halt = (cf[2] ? (dir != idir) : 1'b1) && !cf[3];
    assign aft_dir  = cf[2] ? !dir : dir;
    assign aft_idx  = cf[2] ? (dir ? idx - 1'b1 : idx + 1'b1) : (dir ? lo_e : hi_e);

    always_comb begin
      st_n = st; idx_n = idx; dir_n = dir; idir_n = idir;
      tcnt_n = tcnt; pcnt_n = pcnt; pstart_n = pstart;
      if (!ramp_en[c]) begin
        st_n = IDLE;
        tcnt_n = '0;
      end else if (start_we && start_mask[c]) begin
        idx_n = cf[4] ? lo_e : hi_e;
        dir_n = cf[4];
        idir_n = cf[4];
        tcnt_n = '0;
        pcnt_n = lo_m;
        pstart_n = 1'b1;
        st_n = lop_on ? PAUSE : RUN;
      end else if (ms_tick && (st == RUN || st == PAUSE)) begin
        if (!step_end) tcnt_n = tcnt + 1'b1;
        else begin
          tcnt_n = '0;
          if (st == RUN && idx != term) idx_n = dir ? idx + 1'b1 : idx - 1'b1;
          else if (st == RUN && (dir ? hip_on : lop_on)) begin
            st_n = PAUSE;
            pcnt_n = dir ? hi_m : lo_m;
            pstart_n = 1'b0;
          end
          else if (st == PAUSE && pcnt > 1) pcnt_n = pcnt - 1'b1;
          else if (st == PAUSE && pstart) st_n = RUN;
          else if (aft_halt) st_n = HALT;
          else begin
            st_n = RUN;
            idx_n = aft_idx;
            dir_n = aft_dir;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st <= IDLE; idx <= '0; dir <= 1'b0; idir <= 1'b0;
        tcnt <= '0; pcnt <= '0; pstart <= 1'b0;
      end else begin
        st <= st_n; idx <= idx_n; dir <= dir_n; idir <= idir_n;
        tcnt <= tcnt_n; pcnt <= pcnt_n; pstart <= pstart_n;
      end

    assign duty[c*DUTY_W +: DUTY_W] = (st == IDLE) ? '0 : lut[idx];
    assign busy[c] = (st == RUN) || (st == PAUSE);
    assign done[c] = (st == HALT);
  end
endmodule

// File: rtl/lut_ramp_seq_chk.sv
module lut_ramp_seq_chk #(
  parameter int NCH    = 2,
  parameter int DUTY_W = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ms_tick,
  input logic                  lut_we,
  input logic                  start_we,
  input logic [NCH-1:0]        start_mask,
  input logic [NCH-1:0]        ramp_en,
  input logic [NCH*DUTY_W-1:0] duty,
  input logic [NCH-1:0]        busy,
  input logic [NCH-1:0]        done
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R11
    disable_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ramp_en[c] |=> (!busy[c] && !done[c] && duty[c*DUTY_W +: DUTY_W] == '0));
    // R3
    start_launches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_we && start_mask[c] && ramp_en[c]) |=> busy[c]);
    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[c] && !done[c]) |-> duty[c*DUTY_W +: DUTY_W] == '0);
    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy[c] && done[c]));
    // R6
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && ramp_en[c] && !(start_we && start_mask[c])) |=> done[c]);
    // R4
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ms_tick && !lut_we && ramp_en[c] && !(start_we && start_mask[c]))
        |=> $stable(duty[c*DUTY_W +: DUTY_W]));
  end
endmodule

bind lut_ramp_seq lut_ramp_seq_chk #(.NCH(NCH), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .lut_we(lut_we),
  .start_we(start_we), .start_mask(start_mask), .ramp_en(ramp_en),
  .duty(duty), .busy(busy), .done(done));

// File: tb/lut_ramp_seq_test.sv
module lut_ramp_seq_test;
  localparam int NCH = 2, IDX_W = 4, DUTY_W = 9, STEP_W = 9, PAUSE_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic lut_we = 1'b0, start_we = 1'b0;
  logic [IDX_W-1:0] lut_addr = '0;
  logic [DUTY_W-1:0] lut_wdata = '0;
  logic [NCH-1:0] start_mask = '0, ramp_en = '0;
  logic [NCH*5-1:0] walk_cfg = '0;
  logic [NCH*IDX_W-1:0] lo_idx = '0, hi_idx = '0;
  logic [NCH*STEP_W-1:0] step_len = '0;
  logic [NCH*PAUSE_W-1:0] hi_mult = '0, lo_mult = '0;
  logic [NCH*DUTY_W-1:0] duty;
  logic [NCH-1:0] busy, done;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  lut_ramp_seq #(.NCH(NCH), .IDX_W(IDX_W), .DUTY_W(DUTY_W), .STEP_W(STEP_W), .PAUSE_W(PAUSE_W)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .lut_we(lut_we), .lut_addr(lut_addr),
    .lut_wdata(lut_wdata), .start_we(start_we), .start_mask(start_mask), .ramp_en(ramp_en),
    .walk_cfg(walk_cfg), .lo_idx(lo_idx), .hi_idx(hi_idx), .step_len(step_len),
    .hi_mult(hi_mult), .lo_mult(lo_mult), .duty(duty), .busy(busy), .done(done));

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] cfg;
    logic [3:0] lo, hi, stp, him, lom;
    logic [7:0] n;
    logic [3:0] xidx;
    logic       xdone;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{4'd4,  5'b11000, 4'd2, 4'd4, 4'd2, 4'd0, 4'd0, 8'd0,  4'd2,  1'b0}, // R4 start low
    '{4'd4,  5'b11000, 4'd2, 4'd4, 4'd2, 4'd0, 4'd0, 8'd3,  4'd3,  1'b0}, // R4
    '{4'd4,  5'b11000, 4'd2, 4'd4, 4'd2, 4'd0, 4'd0, 8'd5,  4'd4,  1'b0}, // R4
    '{4'd5,  5'b11000, 4'd2, 4'd4, 4'd2, 4'd0, 4'd0, 8'd6,  4'd2,  1'b0}, // R5 wrap
    '{4'd6,  5'b10000, 4'd2, 4'd4, 4'd2, 4'd0, 4'd0, 8'd5,  4'd4,  1'b0}, // R6
    '{4'd6,  5'b10000, 4'd2, 4'd4, 4'd2, 4'd0, 4'd0, 8'd6,  4'd4,  1'b1}, // R6 done
    '{4'd6,  5'b10000, 4'd2, 4'd4, 4'd2, 4'd0, 4'd0, 8'd20, 4'd4,  1'b1}, // R6 holds
    '{4'd9,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd0,  4'd2,  1'b0}, // R9
    '{4'd9,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd1,  4'd2,  1'b0}, // R9 start pause
    '{4'd7,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd2,  4'd3,  1'b0}, // R7
    '{4'd8,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd3,  4'd4,  1'b0}, // R8
    '{4'd8,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd5,  4'd4,  1'b0}, // R8 hi pause
    '{4'd7,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd6,  4'd3,  1'b0}, // R7 reverse
    '{4'd9,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd8,  4'd2,  1'b0}, // R9 low end
    '{4'd7,  5'b11111, 4'd2, 4'd4, 4'd1, 4'd2, 4'd1, 8'd9,  4'd3,  1'b0}, // R7 again
    '{4'd7,  5'b00100, 4'd2, 4'd4, 4'd1, 4'd0, 4'd0, 8'd0,  4'd4,  1'b0}, // R7 start high
    '{4'd7,  5'b00100, 4'd2, 4'd4, 4'd1, 4'd0, 4'd0, 8'd2,  4'd2,  1'b0}, // R7
    '{4'd7,  5'b00100, 4'd2, 4'd4, 4'd1, 4'd0, 4'd0, 8'd3,  4'd3,  1'b0}, // R7
    '{4'd6,  5'b00100, 4'd2, 4'd4, 4'd1, 4'd0, 4'd0, 8'd4,  4'd4,  1'b0}, // R6
    '{4'd6,  5'b00100, 4'd2, 4'd4, 4'd1, 4'd0, 4'd0, 8'd5,  4'd4,  1'b1}, // R6
    '{4'd10, 5'b11000, 4'd7, 4'd7, 4'd1, 4'd0, 4'd0, 8'd0,  4'd0,  1'b0}, // R10
    '{4'd10, 5'b11000, 4'd7, 4'd7, 4'd1, 4'd0, 4'd0, 8'd15, 4'd15, 1'b0}, // R10
    '{4'd10, 5'b11000, 4'd7, 4'd7, 4'd1, 4'd0, 4'd0, 8'd16, 4'd0,  1'b0}, // R10
    '{4'd4,  5'b01000, 4'd3, 4'd5, 4'd3, 4'd0, 4'd0, 8'd0,  4'd5,  1'b0}, // R4 reverse
    '{4'd4,  5'b01000, 4'd3, 4'd5, 4'd3, 4'd0, 4'd0, 8'd4,  4'd4,  1'b0}, // R4
    '{4'd4,  5'b01000, 4'd3, 4'd5, 4'd3, 4'd0, 4'd0, 8'd8,  4'd3,  1'b0}, // R4
    '{4'd5,  5'b01000, 4'd3, 4'd5, 4'd3, 4'd0, 4'd0, 8'd9,  4'd5,  1'b0}, // R5
    '{4'd8,  5'b11010, 4'd1, 4'd2, 4'd1, 4'd3, 4'd0, 8'd1,  4'd2,  1'b0}, // R8
    '{4'd8,  5'b11010, 4'd1, 4'd2, 4'd1, 4'd3, 4'd0, 8'd4,  4'd2,  1'b0}, // R8
    '{4'd5,  5'b11010, 4'd1, 4'd2, 4'd1, 4'd3, 4'd0, 8'd5,  4'd1,  1'b0}  // R5
  };

  function automatic logic [DUTY_W-1:0] lv(input int k);
    return DUTY_W'(10 * k + 5);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setch(input int c, input logic [4:0] cf, input int lo, input int hi,
                       input int st, input int him, input int lom);
    walk_cfg[c*5 +: 5] = cf;
    lo_idx[c*IDX_W +: IDX_W] = IDX_W'(lo);
    hi_idx[c*IDX_W +: IDX_W] = IDX_W'(hi);
    step_len[c*STEP_W +: STEP_W] = STEP_W'(st);
    hi_mult[c*PAUSE_W +: PAUSE_W] = PAUSE_W'(him);
    lo_mult[c*PAUSE_W +: PAUSE_W] = PAUSE_W'(lom);
  endtask

  task automatic pulse_start(input logic [NCH-1:0] m);
    start_we = 1'b1; start_mask = m;
    @(negedge clk);
    start_we = 1'b0; start_mask = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 duty", int'(duty), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      lut_we = 1'b1; lut_addr = IDX_W'(k); lut_wdata = lv(k);
      @(negedge clk);
    end
    lut_we = 1'b0;
    ramp_en = 2'b01;
    ms_tick = 1'b1;

    for (int v = 0; v < NV; v++) begin
      setch(0, VT[v].cfg, VT[v].lo, VT[v].hi, VT[v].stp, VT[v].him, VT[v].lom);
      pulse_start(2'b01);
      repeat (int'(VT[v].n)) @(negedge clk);
      check($sformatf("R%0d vec%0d duty", VT[v].req, v), int'(duty[8:0]), int'(lv(VT[v].xidx)));
      check($sformatf("R%0d vec%0d done", VT[v].req, v), int'(done[0]), int'(VT[v].xdone));
    end

    // R4: no tick, no progress
    setch(0, 5'b11000, 2, 4, 1, 0, 0);
    pulse_start(2'b01);
    ms_tick = 1'b0;
    repeat (10) @(negedge clk);
    check("R4 no tick", int'(duty[8:0]), int'(lv(2)));

    // R2: table write visible on running channel
    lut_we = 1'b1; lut_addr = 4'd2; lut_wdata = 9'd300;
    @(negedge clk);
    lut_we = 1'b0;
    check("R2 rewrite", int'(duty[8:0]), 300);
    lut_we = 1'b1; lut_wdata = lv(2);
    @(negedge clk);
    lut_we = 1'b0;
    ms_tick = 1'b1;

    // R11: disable stops immediately
    ramp_en = 2'b00;
    @(negedge clk);
    check("R11 busy", int'(busy[0]), 0);
    check("R11 duty", int'(duty[8:0]), 0);

    // R3: start ignored while disabled
    pulse_start(2'b01);
    check("R3 ignored", int'(busy[0]), 0);

    // R3: shared start launches both
    ramp_en = 2'b11;
    setch(1, 5'b11000, 5, 6, 1, 0, 0);
    pulse_start(2'b11);
    check("R3 ch0 duty", int'(duty[8:0]), int'(lv(2)));
    check("R3 ch1 duty", int'(duty[17:9]), int'(lv(5)));
    check("R3 both busy", int'(busy), 3);

    // R3: unmasked channel unaffected
    ramp_en = 2'b01;
    @(negedge clk);
    ramp_en = 2'b11;
    pulse_start(2'b01);
    check("R3 ch1 idle", int'(busy[1]), 0);
    check("R3 ch0 busy", int'(busy[0]), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule